// File: doc/BRIEF.md
# Serial Transmit Path with Priority Queue

This block is the send side of one asynchronous serial channel. Bytes arrive on two write ports. The first port feeds a 255-entry queue for ordinary data. The second feeds a 32-entry queue for urgent bytes, such as flow-control characters. A single holding register sits between the two queues and a frame shifter. Whenever that holding register is free, it takes the next byte from the urgent queue if that queue has data, and otherwise from the ordinary queue. As a result, urgent bytes overtake every byte that is still waiting in the ordinary queue.

The frame shape is set by a small character configuration: 7 or 8 data bits, optional parity (odd or even), and one or two stop bits. The bit clock is the system clock divided by a fixed prescaler of 10, then divided again by a 16-bit divisor plus one. Each serial bit lasts 16 of those divided ticks.

Several controls can stop or hold the line:
- **Transmit enable.** Clearing it stops refills of the holding register. The byte currently shifting and the byte in the holding register still go out.
- **CTS flow control.** When enabled and CTS is low, no new character starts.
- **Software stop.** A pulse halts ordinary-queue refills and a resume pulse releases them; urgent bytes keep flowing while stopped.
- **Break.** Drives the line low for as long as it is set.

Top module: `uart_tx_path`

## Requirements
- R1: After reset the serial output is 1, `tx_stat` reads 8'h06 (bits 2 and 1 set, all others 0), `norm_level` is 0 and `prio_stat` is 0.
- R2: Frame bit order, from first sent to last:
  - one start bit at 0;
  - the data bits, LSB first — 8 of them when `char_cfg[0]`=1, or 7 when it is 0;
  - a parity bit, only when `char_cfg[2]`=1 — it makes the count of ones even when `char_cfg[1]`=1 and odd when `char_cfg[1]`=0;
  - stop bits at 1 — two when `char_cfg[3]`=1, one when it is 0.

  The line idles at 1.
- R3: Every bit, including the start bit, lasts exactly 160×(`baud_div`+1) clock cycles.
- R4: A byte in the urgent queue is always sent before any byte still held in the ordinary queue. A byte already in the holding register keeps its place. `prio_stat[7]` is 1 whenever the urgent queue is not empty, and `prio_stat[6:0]` gives its fill count.
- R5: While `line_cfg[0]` (transmit enable) is 0, neither queue gives up a byte. The character being shifted and the byte in the holding register are still sent, so at most two bytes go out after the enable is cleared.
- R6: With `char_cfg[4]`=1 and `cts` low, no new character starts. A character that has already started completes. With `char_cfg[4]`=0, `cts` has no effect.
- R7: A one-cycle pulse on `xoff_stop` blocks transfers from the ordinary queue. Urgent bytes still pass. A pulse on `xoff_resume` releases the block and wins if both pulses arrive together.
- R8: While `line_cfg[1]` is 1, the serial output is held at 0 from the next cycle and no new character starts. Once it clears, pending bytes are sent normally.
- R9: `tx_stat[2]` is 1 only when both queues and the holding register are empty. `tx_stat[1]` is 1 only when no character is being shifted. The channel is drained when both bits are 1.
- R10: A write to a full queue is dropped. The ordinary queue tops out at 255 entries and the urgent queue at 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| norm_wr | input | 1 | Write strobe for the ordinary queue |
| norm_data | input | 8 | Byte for the ordinary queue |
| prio_wr | input | 1 | Write strobe for the urgent queue |
| prio_data | input | 8 | Byte for the urgent queue |
| char_cfg | input | 5 | Character configuration: bit 4 CTS flow control, bit 3 two stop bits, bit 2 parity on, bit 1 even parity, bit 0 eight data bits |
| line_cfg | input | 2 | Line control: bit 1 break, bit 0 transmit enable |
| baud_div | input | 16 | Bit-rate divisor |
| cts | input | 1 | Clear-to-send, high when asserted |
| xoff_stop | input | 1 | Pulse that halts ordinary-queue transfers |
| xoff_resume | input | 1 | Pulse that releases the halt |
| txd | output | 1 | Serial data output |
| norm_level | output | 8 | Ordinary queue fill count |
| prio_stat | output | 8 | Bit 7 urgent-data-pending flag, bits 6:0 urgent queue fill count |
| tx_stat | output | 8 | Bit 2 all queues and holding register empty, bit 1 shifter idle, other bits 0 |

## Verification
The bench decodes the serial line as it runs and checks each frame against a queue of expected bytes. That queue is built from the requirements.

The data patterns are chosen to expose specific faults:
- All-ones and all-zeros bytes, plus mixed bytes, separate bit-order errors from parity errors. An all-ones byte also leaves the start bit as the only low run, which gives a clean measurement of the bit time.
- 8N1, 7E2 and 8O1 formats each stress a different data, parity and stop combination.
- An urgent byte written while an ordinary burst is in flight shows whether it overtakes the queue but not the holding register.
- Clearing transmit enable, dropping CTS, issuing a software stop and raising break mid-stream each show whether exactly the right stage is frozen.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int FRAME_W = 12;

  typedef struct packed {
    logic cts_flow;
    logic two_stop;
    logic par_en;
    logic par_even;
    logic data8;
  } char_cfg_t;

  // parity bit that completes the requested ones count
  function automatic logic parity_bit(input logic [7:0] d, input char_cfg_t c);
    logic ones;
    ones = c.data8 ? ^d : ^d[6:0];
    return c.par_even ? ones : ~ones;
  endfunction

  // number of line bits in one character
  function automatic logic [3:0] frame_len(input char_cfg_t c);
    logic [3:0] n;
    n = 4'd9;
    if (c.data8)    n = n + 4'd1;
    if (c.par_en)   n = n + 4'd1;
    if (c.two_stop) n = n + 4'd1;
    return n;
  endfunction

  // frame image, bit 0 leaves first; unused upper positions stay 1
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d, input char_cfg_t c);
    logic [FRAME_W-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || c.data8) f[i+1] = d[i];
    end
    if (c.par_en) begin
      if (c.data8) f[9] = parity_bit(d, c);
      else         f[8] = parity_bit(d, c);
    end
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
  parameter int DEPTH = 255,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, wr_ok, rd_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign wr_ok   = wr_i && !full;
  assign rd_ok   = rd_i && !empty_o;
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_i && !rd_i) |=> (count_o == $past(count_o)));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int PRESCALE = 10,
  parameter int DIV_W    = 16,
  localparam int PCW     = $clog2(PRESCALE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [PCW-1:0]   pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_hit, div_hit;

  assign pre_hit = (pre_cnt == PCW'(PRESCALE - 1));
  assign div_hit = (div_cnt >= div_i);
  assign tick_o  = pre_hit && div_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
      if (pre_hit) div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end
  end

  if (PRESCALE > 1) begin : g_spacing
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  localparam int SW        = $clog2(OVERSAMPLE)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      avail_i,
  input  logic [7:0] data_i,
  input  char_cfg_t cfg_i,
  input  logic      brk_i,
  input  logic      cts_i,
  output logic      take_o,
  output logic      busy_o,
  output logic      txd_o
);

  logic [FRAME_W-1:0] shreg;
  logic [3:0]         left;
  logic [SW-1:0]      sub;
  logic               go;

  assign go     = avail_i && !brk_i && (!cfg_i.cts_flow || cts_i);
  assign take_o = tick_i && !busy_o && go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      shreg  <= '1;
      left   <= '0;
      sub    <= '0;
      txd_o  <= 1'b1;
    end else begin
      txd_o <= brk_i ? 1'b0 : (busy_o ? shreg[0] : 1'b1);
      if (take_o) begin
        shreg  <= build_frame(data_i, cfg_i);
        left   <= frame_len(cfg_i);
        sub    <= '0;
        busy_o <= 1'b1;
      end else if (busy_o && tick_i) begin
        if (sub == SW'(OVERSAMPLE - 1)) begin
          sub   <= '0;
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - 4'd1;
          if (left == 4'd1) busy_o <= 1'b0;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  a_r6_cts_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.cts_flow && !cts_i && !busy_o) |=> !busy_o);

  a_r8_break_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && !busy_o) |=> !busy_o);

  a_r8_break_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> !txd_o);

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int NORM_DEPTH = 255,
  parameter int PRIO_DEPTH = 32,
  parameter int PRESCALE   = 10,
  parameter int OVERSAMPLE = 16,
  parameter int DIV_W      = 16,
  localparam int NCW       = $clog2(NORM_DEPTH + 1),
  localparam int PCW       = $clog2(PRIO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             norm_wr,
  input  logic [7:0]       norm_data,
  input  logic             prio_wr,
  input  logic [7:0]       prio_data,
  input  logic [4:0]       char_cfg,
  input  logic [1:0]       line_cfg,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             cts,
  input  logic             xoff_stop,
  input  logic             xoff_resume,
  output logic             txd,
  output logic [NCW-1:0]   norm_level,
  output logic [7:0]       prio_stat,
  output logic [7:0]       tx_stat
);

  char_cfg_t      cc;
  logic           tx_en, brk;
  logic           tick, take, busy;
  logic           norm_empty, prio_empty;
  logic [7:0]     norm_rdata, prio_rdata;
  logic [PCW-1:0] pcount;
  logic           norm_pop, prio_pop;
  logic           hold_full, xoff_q, all_empty;
  logic [7:0]     hold_data;

  assign cc    = char_cfg_t'(char_cfg);
  assign tx_en = line_cfg[0];
  assign brk   = line_cfg[1];

  // urgent queue wins the holding register; software stop gates only the ordinary queue
  assign prio_pop = !hold_full && tx_en && !prio_empty;
  assign norm_pop = !hold_full && tx_en && !xoff_q && prio_empty && !norm_empty;

  uart_tx_queue #(.DEPTH(NORM_DEPTH), .W(8)) u_norm (
    .clk(clk), .rst_n(rst_n), .wr_i(norm_wr), .wdata_i(norm_data),
    .rd_i(norm_pop), .rdata_o(norm_rdata), .count_o(norm_level), .empty_o(norm_empty)
  );

  uart_tx_queue #(.DEPTH(PRIO_DEPTH), .W(8)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_i(prio_wr), .wdata_i(prio_data),
    .rd_i(prio_pop), .rdata_o(prio_rdata), .count_o(pcount), .empty_o(prio_empty)
  );

  uart_tx_baud #(.PRESCALE(PRESCALE), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_i(baud_div), .tick_o(tick)
  );

  uart_tx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .avail_i(hold_full), .data_i(hold_data),
    .cfg_i(cc), .brk_i(brk), .cts_i(cts), .take_o(take), .busy_o(busy), .txd_o(txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      xoff_q    <= 1'b0;
    end else begin
      if (take)                     hold_full <= 1'b0;
      else if (prio_pop || norm_pop) hold_full <= 1'b1;
      if (prio_pop)      hold_data <= prio_rdata;
      else if (norm_pop) hold_data <= norm_rdata;
      if (xoff_resume)    xoff_q <= 1'b0;
      else if (xoff_stop) xoff_q <= 1'b1;
    end
  end

  assign all_empty = !hold_full && norm_empty && prio_empty;
  assign prio_stat = {!prio_empty, 7'(pcount)};
  assign tx_stat   = {5'b0, all_empty, !busy, 1'b0};

  a_r4_prio_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (pcount != '0) |=> (norm_level >= $past(norm_level)));

  a_r5_disable_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (norm_level >= $past(norm_level) && pcount >= $past(pcount)));

  a_r7_xoff_holds_normal: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_q |=> (norm_level >= $past(norm_level)));

  a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stat[2] && tx_stat[1] && !brk && !$past(brk)) |-> txd);

endmodule

// File: tb/sim_uart_tx_path.sv
`timescale 1ns/1ps
module sim_uart_tx_path;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        norm_wr = 1'b0, prio_wr = 1'b0;
  logic [7:0]  norm_data = '0, prio_data = '0;
  logic [4:0]  char_cfg = 5'b00001;
  logic [1:0]  line_cfg = 2'b01;
  logic [15:0] baud_div = '0;
  logic        cts = 1'b1, xoff_stop = 1'b0, xoff_resume = 1'b0;
  logic        txd;
  logic [7:0]  norm_level, prio_stat, tx_stat;

  always #10 clk = ~clk;

  uart_tx_path u0 (
    .clk(clk), .rst_n(rst_n), .norm_wr(norm_wr), .norm_data(norm_data),
    .prio_wr(prio_wr), .prio_data(prio_data), .char_cfg(char_cfg), .line_cfg(line_cfg),
    .baud_div(baud_div), .cts(cts), .xoff_stop(xoff_stop), .xoff_resume(xoff_resume),
    .txd(txd), .norm_level(norm_level), .prio_stat(prio_stat), .tx_stat(tx_stat)
  );

  int checks = 0, errors = 0;
  int exp_q[$];
  int rx_count = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural line receiver, evaluated on every clock
  int m_state = 0, m_t = 0, m_bt = 0, m_len = 0, m_k = 0;
  logic [4:0]  m_cfg;
  logic [11:0] m_bits;
  logic        prev_txd = 1'b1;
  int low_run = 0, last_low = 0;
  int d_nd, d_val, d_pos, d_ones, d_exp;
  bit d_ok;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_state = 0; prev_txd = 1'b1; low_run = 0;
    end else begin
      if (txd == 1'b0) low_run++;
      else if (prev_txd == 1'b0) begin last_low = low_run; low_run = 0; end
      if (m_state == 0) begin
        if (prev_txd && !txd && !line_cfg[1]) begin
          m_state = 1; m_t = 1; m_k = 0; m_cfg = char_cfg;
          m_bt  = 160 * (int'(baud_div) + 1);
          m_len = 1 + (m_cfg[0] ? 8 : 7) + (m_cfg[2] ? 1 : 0) + (m_cfg[3] ? 2 : 1);
        end
      end else begin
        if (m_t % m_bt == m_bt / 2) begin
          m_bits[m_k] = txd;
          m_k++;
          if (m_k == m_len) begin
            d_nd = m_cfg[0] ? 8 : 7;
            d_ok = (m_bits[0] == 1'b0);
            d_val = 0;
            for (int i = 0; i < d_nd; i++) d_val |= int'(m_bits[1+i]) << i;
            d_pos = 1 + d_nd;
            if (m_cfg[2]) begin
              d_ones = $countones(d_val);
              d_ok &= (int'(m_bits[d_pos]) == (m_cfg[1] ? d_ones % 2 : 1 - d_ones % 2));
              d_pos++;
            end
            for (int s = 0; s < (m_cfg[3] ? 2 : 1); s++) d_ok &= (m_bits[d_pos+s] == 1'b1);
            rx_count++;
            if (exp_q.size() == 0) chk(1'b0, "R2/R4 unexpected frame", d_val, -1);
            else begin
              d_exp = exp_q.pop_front();
              chk(d_ok && d_val == d_exp, "R2/R4 frame content and order", d_val, d_exp);
            end
            m_state = 0;
          end
        end
        m_t++;
      end
      prev_txd = txd;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_norm(input logic [7:0] d);
    norm_data = d; norm_wr = 1'b1; step(1); norm_wr = 1'b0;
  endtask

  task automatic wr_prio(input logic [7:0] d);
    prio_data = d; prio_wr = 1'b1; step(1); prio_wr = 1'b0;
  endtask

  task automatic wait_drained(input string req);
    int n = 0;
    step(1);
    while (!(tx_stat[2] && tx_stat[1] && m_state == 0) && n < 60000) begin step(1); n++; end
    step(4);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc;
    step(5);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk(txd == 1'b1, "R1 idle line", txd, 1);
    chk(tx_stat == 8'h06, "R1 status after reset", tx_stat, 8'h06);
    chk(norm_level == 0 && prio_stat == 0, "R1 counts after reset", {norm_level, prio_stat}, 0);

    // R2 R3: 8N1, divisor 0
    exp_q.push_back(8'hFF);
    wr_norm(8'hFF);
    wait_drained("R2 8N1 single");
    chk(last_low == 160, "R3 bit time divisor 0", last_low, 160);
    exp_q.push_back(8'hA5); exp_q.push_back(8'h00); exp_q.push_back(8'h3C);
    wr_norm(8'hA5); wr_norm(8'h00); wr_norm(8'h3C);
    wait_drained("R2 8N1 burst");

    // R2 R3: 7 bits, even parity, 2 stops, divisor 1
    char_cfg = 5'b01110; baud_div = 16'd1;
    exp_q.push_back(8'h7F);
    wr_norm(8'hFF);
    wait_drained("R2 7E2 top bit dropped");
    chk(last_low == 320, "R3 bit time divisor 1", last_low, 320);
    exp_q.push_back(8'h35);
    wr_norm(8'h35);
    wait_drained("R2 7E2");

    // R2: 8 bits odd parity
    char_cfg = 5'b00101; baud_div = 16'd0;
    exp_q.push_back(8'h00); exp_q.push_back(8'h81);
    wr_norm(8'h00); wr_norm(8'h81);
    wait_drained("R2 8O1");

    // R4: urgent byte overtakes queued ordinary bytes, not the holding register
    char_cfg = 5'b00001;
    exp_q.push_back(8'hA1); exp_q.push_back(8'hA2); exp_q.push_back(8'hE7);
    exp_q.push_back(8'hA3); exp_q.push_back(8'hA4);
    wr_norm(8'hA1); wr_norm(8'hA2); wr_norm(8'hA3); wr_norm(8'hA4);
    step(400);
    wr_prio(8'hE7);
    step(1);
    chk(prio_stat == 8'h81, "R4 pending flag and count", prio_stat, 8'h81);
    wait_drained("R4 priority order");

    // R5: clearing enable lets exactly two bytes drain
    exp_q.push_back(8'hB1); exp_q.push_back(8'hB2);
    wr_norm(8'hB1); wr_norm(8'hB2); wr_norm(8'hB3); wr_norm(8'hB4);
    while (tx_stat[1]) step(1);
    step(3);
    line_cfg = 2'b00;
    step(5000);
    chk(exp_q.size() == 0, "R5 two bytes drained", exp_q.size(), 0);
    chk(norm_level == 2, "R5 remaining bytes held", norm_level, 2);
    chk(tx_stat[2:1] == 2'b01, "R9 queue not empty, shifter idle", tx_stat[2:1], 1);
    exp_q.push_back(8'hB3); exp_q.push_back(8'hB4);
    line_cfg = 2'b01;
    wait_drained("R5 resume after enable");

    // R6: CTS flow control
    char_cfg = 5'b10001; cts = 1'b0;
    rc = rx_count;
    wr_norm(8'hC1);
    step(4000);
    chk(rx_count == rc, "R6 no start while CTS low", rx_count, rc);
    chk(tx_stat[2:1] == 2'b01, "R9 holding byte reported", tx_stat[2:1], 1);
    exp_q.push_back(8'hC1);
    cts = 1'b1;
    wait_drained("R6 start after CTS");
    char_cfg = 5'b00001; cts = 1'b0;
    exp_q.push_back(8'hC2);
    wr_norm(8'hC2);
    wait_drained("R6 CTS ignored when flow off");
    cts = 1'b1;

    // R7: software stop
    xoff_stop = 1'b1; step(1); xoff_stop = 1'b0;
    rc = rx_count;
    wr_norm(8'hD1);
    step(4000);
    chk(rx_count == rc, "R7 ordinary byte held", rx_count, rc);
    chk(norm_level == 1, "R7 ordinary queue level", norm_level, 1);
    exp_q.push_back(8'hD9);
    wr_prio(8'hD9);
    step(3000);
    chk(exp_q.size() == 0, "R7 urgent byte passes", exp_q.size(), 0);
    exp_q.push_back(8'hD1);
    xoff_resume = 1'b1; step(1); xoff_resume = 1'b0;
    wait_drained("R7 resume");

    // R8: break
    line_cfg = 2'b11;
    step(3);
    chk(txd == 1'b0, "R8 break drives line low", txd, 0);
    rc = rx_count;
    wr_norm(8'hE1);
    step(3000);
    chk(txd == 1'b0 && rx_count == rc, "R8 no character during break", {txd, rx_count[7:0]}, {1'b0, rc[7:0]});
    chk(tx_stat[2:1] == 2'b01, "R8 shifter idle during break", tx_stat[2:1], 1);
    exp_q.push_back(8'hE1);
    line_cfg = 2'b01;
    wait_drained("R8 byte after break");

    // R10: full queues drop writes
    line_cfg = 2'b00;
    for (int i = 0; i < 256; i++) wr_norm(8'(i));
    chk(norm_level == 255, "R10 ordinary queue limit", norm_level, 255);
    for (int i = 0; i < 33; i++) wr_prio(8'(i));
    chk(prio_stat == 8'hA0, "R10 urgent queue limit", prio_stat, 8'hA0);
    chk(tx_stat[2] == 1'b0, "R9 not empty when full", tx_stat[2], 0);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(norm_level == 0 && prio_stat == 0 && tx_stat == 8'h06, "R1 reset clears", {norm_level, prio_stat, tx_stat}, 8'h06);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule